// File: doc/BRIEF.md
# Register-Access Serial Slave Port

This block is a four-wire serial slave port that lets a host processor read and write a bank of internal registers. The registers have widths of 8, 12, 16 and 24 bits. Every transaction starts with an 8-bit command byte. Its top bit chooses the direction and its low six bits name one of 64 locations. A data phase follows, one whole number of bytes long and sent most significant bit first. The serial clock, chip select and data input are brought into the system clock domain through synchronizers, and all framing runs from edges found on the synchronized serial clock.

The bank built here is a small example of eight registers whose widths come from a table indexed by address. It also holds a read-only checksum location. That location reports how many one-bits were in the word returned by the most recent completed read. Chip select is active low. A host that keeps it low permanently must finish every transfer, because the bit counter only re-frames at the end of a transfer or when chip select goes high.

Top module: `reg_serial_port`

## Requirements
- R1: The command byte is taken MSB first on falling edges of `sclk`. Bit 7 = 1 means write and bit 7 = 0 means read. Bits 5:0 hold the address, and bit 6 is ignored.
- R2: For addresses below 8, address bits 1:0 set the register width: 0 gives 8 bits, 1 gives 12, 2 gives 16 and 3 gives 24. The transfer length is the width rounded up to whole bytes (1, 2, 2 or 3 bytes). Address 0x3F and all other addresses transfer one byte.
- R3: Write data is taken MSB first on falling edges of `sclk`. Only the register's low width bits are kept. A write to 0x3F or to an address of 8 or above has no effect.
- R4: Read data is driven on rising edges of `sclk`, MSB first, with bits above the register width read as zero. Addresses 8 to 0x3E read as zero.
- R5: `sdo_oe` is low while idle and during the command byte. It rises on the first rising `sclk` edge after a read command, and it falls on the falling edge that ends the last data bit.
- R6: Reading 0x3F returns the number of one-bits in the word of the last completed read of any other address. The value is 0 after reset, and reads of 0x3F leave it unchanged.
- R7: Raising `cs_n` aborts any transfer and re-arms the port for a command byte. An aborted write changes no register, an aborted read leaves the checksum unchanged, and `sdo_oe` drops.
- R8: With `cs_n` held low, consecutive complete transfers are framed back to back correctly.
- R9: After reset `sdo_oe` is low and every register and the checksum read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for the serial output line |

## Verification
Each serial edge passes through two synchronizer stages and one edge-detect register, so the port acts on it about three system clocks later. An output bit driven on a rising edge is therefore valid within four clocks, and the end-of-read release of `sdo_oe` follows the last falling edge by a similar margin. The bench holds each `sclk` level for eight system clocks. It samples `sdo` and `sdo_oe` at the end of each high phase, and it samples the post-transfer and post-abort state a full half period after the deciding edge, so every sample falls well after the output is due.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_WRITE,
    PH_READ
  } phase_t;

  // Stored width of a location: the example bank decodes addr[1:0];
  // the checksum and unbuilt locations are one byte wide.
  function automatic int reg_bits(input int addr, input int depth, input int csum_addr);
    if (addr < depth && addr != csum_addr) begin
      case (addr % 4)
        0:       return 8;
        1:       return 12;
        2:       return 16;
        default: return 24;
      endcase
    end
    return 8;
  endfunction

  // Serial length of a location, rounded up to whole bytes.
  function automatic int xfer_bits(input int width);
    return ((width + 7) / 8) * 8;
  endfunction

  function automatic int ones_in(input logic [31:0] w);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(w[i]);
    return n;
  endfunction

endpackage

// File: rtl/rsp_sync.sv
module rsp_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rsp_framer.sv
module rsp_framer
  import rsp_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 24,
  parameter int BANK_DEPTH = 8,
  parameter int CSUM_ADDR  = 63,
  localparam int CNT_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_done,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sclk_rise,
  output logic              cs_active,
  output logic [CNT_W-1:0]  bit_cnt
);
  phase_t             phase;
  logic               sclk_d;
  logic               sclk_fall;
  logic [CMD_W-2:0]   cmd_sr;
  logic [CNT_W-1:0]   nbits_q;
  logic [DATA_W-1:0]  data_sr;
  logic [DATA_W-1:0]  rd_aligned;

  assign cs_active  = ~cs_n_s;
  assign sclk_rise  = cs_active & sclk_s & ~sclk_d;
  assign sclk_fall  = cs_active & ~sclk_s & sclk_d;
  // Left-align the padded word so the first byte out is the top byte.
  assign rd_aligned = rd_word << (DATA_W - int'(nbits_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      cmd_sr  <= '0;
      bit_cnt <= '0;
      nbits_q <= CNT_W'(CMD_W);
      addr    <= '0;
      data_sr <= '0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
      rd_done <= 1'b0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      wr_stb  <= 1'b0;
      rd_done <= 1'b0;
      if (!cs_active) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        sdo_oe  <= 1'b0;
      end else begin
        case (phase)
          PH_CMD: begin
            if (sclk_fall) begin
              cmd_sr <= {cmd_sr[CMD_W-3:0], sdi_s};
              if (bit_cnt == CNT_W'(CMD_W - 1)) begin
                addr    <= {cmd_sr[ADDR_W-2:0], sdi_s};
                nbits_q <= CNT_W'(xfer_bits(reg_bits(int'({cmd_sr[ADDR_W-2:0], sdi_s}),
                                                     BANK_DEPTH, CSUM_ADDR)));
                phase   <= cmd_sr[CMD_W-2] ? PH_WRITE : PH_READ;
                bit_cnt <= '0;
                data_sr <= '0;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          PH_WRITE: begin
            if (sclk_fall) begin
              data_sr <= {data_sr[DATA_W-2:0], sdi_s};
              if (bit_cnt == nbits_q - 1'b1) begin
                wr_stb  <= 1'b1;
                wr_data <= {data_sr[DATA_W-2:0], sdi_s};
                phase   <= PH_CMD;
                bit_cnt <= '0;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          PH_READ: begin
            if (sclk_rise) begin
              if (bit_cnt == '0) begin
                sdo     <= rd_aligned[DATA_W-1];
                data_sr <= rd_aligned << 1;
              end else begin
                sdo     <= data_sr[DATA_W-1];
                data_sr <= data_sr << 1;
              end
              sdo_oe  <= 1'b1;
              bit_cnt <= bit_cnt + 1'b1;
            end else if (sclk_fall && bit_cnt == nbits_q) begin
              rd_done <= 1'b1;
              sdo_oe  <= 1'b0;
              phase   <= PH_CMD;
              bit_cnt <= '0;
            end
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/rsp_regbank.sv
module rsp_regbank
  import rsp_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 24,
  parameter int BANK_DEPTH = 8,
  parameter int CSUM_ADDR  = 63,
  parameter int CSUM_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_done,
  output logic [DATA_W-1:0] rd_word,
  output logic [CSUM_W-1:0] csum
);
  logic [DATA_W-1:0] bank_q [BANK_DEPTH];

  for (genvar i = 0; i < BANK_DEPTH; i++) begin : g_reg
    localparam int W = reg_bits(i, BANK_DEPTH, CSUM_ADDR);
    logic [W-1:0] r;
    logic         hit;
    assign hit = wr_stb && (addr == ADDR_W'(i)) && (i != CSUM_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r <= '0;
      else if (hit) r <= wr_data[W-1:0];
    end
    assign bank_q[i] = DATA_W'(r);
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < BANK_DEPTH; i++) begin
      if (addr == ADDR_W'(i)) rd_word = bank_q[i];
    end
    if (addr == ADDR_W'(CSUM_ADDR)) rd_word = DATA_W'(csum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csum <= '0;
    else if (rd_done && addr != ADDR_W'(CSUM_ADDR))
      csum <= CSUM_W'(ones_in(32'(rd_word)));
  end
endmodule

// File: rtl/reg_serial_port.sv
module reg_serial_port #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 24,
  parameter int BANK_DEPTH  = 8,
  parameter int CSUM_ADDR   = 63,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int CSUM_W = $clog2(DATA_W + 1);

  logic              sclk_s, cs_n_s, sdi_s;
  logic [ADDR_W-1:0] addr;
  logic              wr_stb, rd_done, sclk_rise, cs_active;
  logic [DATA_W-1:0] wr_data, rd_word;
  logic [CSUM_W-1:0] csum;
  logic [CNT_W-1:0]  bit_cnt;

  rsp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, cs_n, sdi}),
    .q({sclk_s, cs_n_s, sdi_s})
  );

  rsp_framer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_DEPTH(BANK_DEPTH), .CSUM_ADDR(CSUM_ADDR)
  ) u_framer (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .cs_n_s(cs_n_s), .sdi_s(sdi_s),
    .rd_word(rd_word), .addr(addr),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_done(rd_done),
    .sdo(sdo), .sdo_oe(sdo_oe),
    .sclk_rise(sclk_rise), .cs_active(cs_active), .bit_cnt(bit_cnt)
  );

  rsp_regbank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_DEPTH(BANK_DEPTH),
    .CSUM_ADDR(CSUM_ADDR), .CSUM_W(CSUM_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .addr(addr), .wr_stb(wr_stb), .wr_data(wr_data), .rd_done(rd_done),
    .rd_word(rd_word), .csum(csum)
  );
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
  parameter int CNT_W  = 5,
  parameter int CSUM_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_active,
  input logic              sclk_rise,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              wr_stb,
  input logic              rd_done,
  input logic [CSUM_W-1:0] csum,
  input logic [CNT_W-1:0]  bit_cnt
);
  // R7: an inactive select re-arms framing and releases the line
  assert_abort_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (bit_cnt == '0) && !sdo_oe);

  // R5: the drive enable only turns on in response to a rising serial edge
  assert_oe_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(sclk_rise));

  // R4: output data only changes on a rising serial edge
  assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(sdo));

  // R1: a transfer ends either as a write or as a read, never both
  assert_one_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_done}));

  // R6: the checksum moves only after a completed read
  assert_csum_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> $stable(csum));
endmodule

bind reg_serial_port rsp_checker #(.CNT_W(CNT_W), .CSUM_W(CSUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sclk_rise(sclk_rise),
  .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .rd_done(rd_done),
  .csum(csum), .bit_cnt(bit_cnt)
);

// File: tb/reg_serial_port_bench.sv
module reg_serial_port_bench;
  localparam int HALF = 8;
  localparam int NVEC = 14;
  // {command byte, write data or expected read data}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h80, 24'h0000AB},   // write reg0 (8 bit)
    {8'h81, 24'h00FFFF},   // write reg1 (12 bit) -> upper bits dropped
    {8'h82, 24'h001234},   // write reg2 (16 bit)
    {8'h83, 24'hA5C3F0},   // write reg3 (24 bit)
    {8'hC5, 24'h000ABC},   // write reg5 with bit 6 set
    {8'h00, 24'h0000AB},
    {8'h01, 24'h000FFF},
    {8'h02, 24'h001234},
    {8'h03, 24'hA5C3F0},
    {8'h45, 24'h000ABC},   // read reg5 with bit 6 set
    {8'h3F, 24'h000007},   // ones in 0xABC
    {8'h10, 24'h000000},   // unbuilt location
    {8'h3F, 24'h000000},   // ones in last read (zero word)
    {8'hBF, 24'h000055}    // write to checksum: ignored
  };

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdi = 0;
  logic sdo, sdo_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  reg_serial_port u_reg_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  function automatic int nbytes_of(input logic [7:0] cmd);
    if (cmd[5:0] < 6'd8) begin
      case (cmd[1:0])
        2'd0: return 1;
        2'd1: return 2;
        2'd2: return 2;
        default: return 3;
      endcase
    end
    return 1;
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [23:0] wdata, input int stop_bits,
                      input bit hold_cs, output logic [23:0] rdata,
                      output bit oe_pre, output bit oe_data, output bit oe_post);
    int n;
    int lim;
    n = nbytes_of(cmd) * 8;
    lim = (stop_bits < 0) ? n : stop_bits;
    rdata = '0;
    oe_data = 1;
    if (!hold_cs) begin cs_n = 0; wait_clk(HALF); end
    for (int i = 7; i >= 0; i--) begin
      sdi = cmd[i]; sclk = 1; wait_clk(HALF);
      sclk = 0; wait_clk(HALF);
    end
    oe_pre = sdo_oe;
    for (int k = 0; k < lim; k++) begin
      sdi = wdata[n-1-k]; sclk = 1; wait_clk(HALF);
      rdata = {rdata[22:0], sdo};
      oe_data = oe_data & sdo_oe;
      sclk = 0; wait_clk(HALF);
    end
    if (stop_bits >= 0) begin
      cs_n = 1; wait_clk(HALF);
      oe_post = sdo_oe;
    end else begin
      oe_post = sdo_oe;
      if (!hold_cs) begin cs_n = 1; wait_clk(HALF); end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] rd;
    bit pre, dat, post;
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);

    // R9: reset state
    check("R9 oe idle after reset", 24'(sdo_oe), 24'h0);
    xfer(8'h02, '0, -1, 0, rd, pre, dat, post);
    check("R9 reg2 reset value", rd, 24'h0);
    xfer(8'h3F, '0, -1, 0, rd, pre, dat, post);
    check("R9 R6 checksum reset value", rd, 24'h0);

    // R1 R2 R3 R4 R6: table walk
    for (int v = 0; v < NVEC; v++) begin
      xfer(VEC[v][31:24], VEC[v][23:0], -1, 0, rd, pre, dat, post);
      if (!VEC[v][31]) check($sformatf("R1 R2 R4 R6 vector %0d", v), rd, VEC[v][23:0]);
    end
    xfer(8'h3F, '0, -1, 0, rd, pre, dat, post);
    check("R3 R6 checksum write ignored", rd, 24'h0);

    // R5: output enable timing on a 24-bit read
    xfer(8'h03, '0, -1, 0, rd, pre, dat, post);
    check("R5 oe low before data", 24'(pre), 24'h0);
    check("R5 oe high during data", 24'(dat), 24'h1);
    check("R5 oe low after last bit", 24'(post), 24'h0);
    check("R4 24-bit read", rd, 24'hA5C3F0);

    // R7: aborts
    xfer(8'h00, '0, -1, 0, rd, pre, dat, post);
    xfer(8'h03, '0, 5, 0, rd, pre, dat, post);
    check("R7 oe low after abort", 24'(post), 24'h0);
    xfer(8'h3F, '0, -1, 0, rd, pre, dat, post);
    check("R7 aborted read leaves checksum", rd, 24'h5);
    xfer(8'h80, 24'h11, 4, 0, rd, pre, dat, post);
    xfer(8'h00, '0, -1, 0, rd, pre, dat, post);
    check("R7 aborted write leaves reg0", rd, 24'hAB);

    // R8: chip select held low across transfers
    cs_n = 0; wait_clk(HALF);
    xfer(8'h84, 24'h3C, -1, 1, rd, pre, dat, post);
    xfer(8'h86, 24'hBEEF, -1, 1, rd, pre, dat, post);
    xfer(8'h06, '0, -1, 1, rd, pre, dat, post);
    check("R8 tied-low read reg6", rd, 24'hBEEF);
    check("R8 R5 oe released between transfers", 24'(post), 24'h0);
    xfer(8'h04, '0, -1, 1, rd, pre, dat, post);
    check("R8 tied-low read reg4", rd, 24'h3C);
    xfer(8'h3F, '0, -1, 1, rd, pre, dat, post);
    check("R8 R6 tied-low checksum", rd, 24'h4);
    cs_n = 1; wait_clk(HALF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule